// File: doc/BRIEF.md
# Cost-Aware Victim Selector

This block decides which way of a set-associative cache set is replaced when a miss arrives. Each way carries a cost value and a confidence bit, both kept in an external table. A way whose cost is strictly above a programmable threshold, and whose confidence bit is set, counts as cheap to lose. Such a way belongs to a line whose earlier miss the core hid well behind other work. The selector prefers to evict cheap ways. When several are cheap, it picks one of them pseudo-randomly. When none is cheap, it falls back to the least recently used way. Ways that hold no valid line beat both rules.

The block keeps the recency order of every set itself, as an age stack per set. Hit and fill notifications move a way to most-recently-used. The caller presents the miss set together with the per-way valid, cost and confidence values of that set. The chosen way appears, registered, one cycle later. The associativity is a parameter; 4, 8 and 16 ways are the intended configurations. Parameters that are not powers of two are rejected at elaboration.

Top module: `cost_victim_sel`

## Requirements
- R1: `victim_valid` is high in the cycle after a cycle with `miss_req` high, and low in the cycle after a cycle with `miss_req` low; it is low during and right after reset.
- R2: If any bit of `way_valid` is 0 at the miss, the victim is the lowest-numbered way whose `way_valid` bit is 0, regardless of cost or recency.
- R3: Way i is cheap only when its cost field `way_cost[i*COST_W +: COST_W]` is strictly greater than `cost_thresh` and `way_conf[i]` is 1; a cost equal to the threshold, or a clear confidence bit, disqualifies it.
- R4: When all ways are valid and at least one is cheap, the victim is one of the cheap ways; with exactly one cheap way, it is that way.
- R5: The choice among several cheap ways comes from a free-running pseudo-random source, so repeated misses with the same candidate set do not always return the same way.
- R6: When all ways are valid and none is cheap, the victim is the least recently used way of the miss set.
- R7: After reset every set is ordered way 0 most recent up to way WAYS-1 least recent; a hit or fill makes its way the most recent, and the ways that were more recent than it move down by one place.
- R8: A fill and a hit to the same set in the same cycle update recency with the fill only; to different sets both are applied.
- R9: A miss uses the recency order as it stood before any hit or fill of the same cycle.
- R10: Recency updates to one set leave every other set's order unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| way_valid | input | WAYS | Per-way line valid for the miss set |
| way_cost | input | WAYS*COST_W | Per-way cost fields, way i at bits i*COST_W upward |
| way_conf | input | WAYS | Per-way confidence bits |
| cost_thresh | input | COST_W | Cost threshold for the cheap test |
| miss_req | input | 1 | Request a victim for `miss_set` |
| miss_set | input | SET_W | Set index of the miss |
| hit_en | input | 1 | A hit occurred |
| hit_set | input | SET_W | Set of the hit |
| hit_way | input | WAY_W | Way of the hit |
| fill_en | input | 1 | A line was filled |
| fill_set | input | SET_W | Set of the fill |
| fill_way | input | WAY_W | Way of the fill |
| victim_way | output | WAY_W | Chosen way to evict |
| victim_valid | output | 1 | `victim_way` answers the previous cycle's miss |

## Verification
The hardest situation to reach from the ports is a same-cycle collision: a miss, a hit and a fill all aimed at one set. Only that case tells apart a design that reads the recency order before its update, and that drops the hit in favour of the fill, from one that does not. The stimulus builds a known order, then fires these collisions with the touched way chosen as the current least recent way, so that a wrong ordering moves the next victim. Spread among several cheap candidates is reached by holding one candidate mask over many back-to-back misses and recording which ways come out.

// File: rtl/cvs_pkg.sv
package cvs_pkg;

   typedef enum logic [1:0] {
      SRC_EMPTY = 2'd0,
      SRC_CHEAP = 2'd1,
      SRC_AGED  = 2'd2
   } victim_src_e;

   function automatic bit is_pow2(input int n);
      return (n > 1) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/cvs_lfsr.sv
module cvs_lfsr #(
   parameter int          LFSR_W = 16,
   parameter logic [63:0] POLY   = 64'hB400,
   parameter logic [63:0] SEED   = 64'h1ACE
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [LFSR_W-1:0] state
);

   localparam logic [LFSR_W-1:0] TAPS = POLY[LFSR_W-1:0];
   localparam logic [LFSR_W-1:0] INIT = SEED[LFSR_W-1:0];

   generate
      if (INIT == '0) begin : g_bad_seed
         $error("cvs_lfsr: seed must be non-zero");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= INIT;
      end else begin
         state <= (state >> 1) ^ (state[0] ? TAPS : '0);
      end
   end

endmodule

// File: rtl/cvs_pick.sv
module cvs_pick #(
   parameter int WAYS  = 8,
   parameter int RND_W = 16
) (
   input  logic [WAYS-1:0]         mask,
   input  logic [RND_W-1:0]        rnd,
   output logic [$clog2(WAYS)-1:0] sel,
   output logic                    any
);

   localparam int WAY_W = $clog2(WAYS);
   localparam int CNT_W = $clog2(WAYS + 1);

   logic [CNT_W-1:0] cnt;
   logic [RND_W-1:0] idx;
   logic [RND_W-1:0] seen;

   always_comb begin
      cnt = '0;
      for (int w = 0; w < WAYS; w++) begin
         cnt = cnt + CNT_W'(mask[w]);
      end
   end

   assign any = |mask;
   assign idx = (cnt == '0) ? '0 : (rnd % RND_W'(cnt));

   always_comb begin
      sel  = '0;
      seen = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (mask[w]) begin
            if (seen == idx) begin
               sel = WAY_W'(w);
            end
            seen = seen + 1'b1;
         end
      end
   end

endmodule

// File: rtl/cvs_recency.sv
module cvs_recency #(
   parameter int WAYS = 8,
   parameter int SETS = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    hit_en,
   input  logic [$clog2(SETS)-1:0] hit_set,
   input  logic [$clog2(WAYS)-1:0] hit_way,
   input  logic                    fill_en,
   input  logic [$clog2(SETS)-1:0] fill_set,
   input  logic [$clog2(WAYS)-1:0] fill_way,
   input  logic [$clog2(SETS)-1:0] rd_set,
   output logic [$clog2(WAYS)-1:0] lru_way
);

   localparam int WAY_W = $clog2(WAYS);
   localparam int SET_W = $clog2(SETS);
   localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

   logic [WAYS-1:0][WAY_W-1:0] age_all [SETS];
   logic [WAYS-1:0][WAY_W-1:0] rd_age;

   for (genvar s = 0; s < SETS; s++) begin : g_set
      logic                       touch;
      logic [WAY_W-1:0]           tway;
      logic [WAYS-1:0][WAY_W-1:0] age_q;

      always_comb begin
         touch = 1'b0;
         tway  = '0;
         if (fill_en && (fill_set == SET_W'(s))) begin
            touch = 1'b1;
            tway  = fill_way;
         end else if (hit_en && (hit_set == SET_W'(s))) begin
            touch = 1'b1;
            tway  = hit_way;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int w = 0; w < WAYS; w++) begin
               age_q[w] <= WAY_W'(w);
            end
         end else if (touch) begin
            for (int w = 0; w < WAYS; w++) begin
               if (WAY_W'(w) == tway) begin
                  age_q[w] <= '0;
               end else if (age_q[w] < age_q[tway]) begin
                  age_q[w] <= age_q[w] + 1'b1;
               end
            end
         end
      end

      assign age_all[s] = age_q;
   end

   assign rd_age = age_all[rd_set];

   always_comb begin
      lru_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (rd_age[w] == OLDEST) begin
            lru_way = WAY_W'(w);
         end
      end
   end

endmodule

// File: rtl/cost_victim_sel.sv
module cost_victim_sel #(
   parameter int          WAYS      = 8,
   parameter int          SETS      = 16,
   parameter int          COST_W    = 5,
   parameter int          LFSR_W    = 16,
   parameter logic [63:0] LFSR_POLY = 64'hB400,
   parameter logic [63:0] LFSR_SEED = 64'h1ACE
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [WAYS-1:0]          way_valid,
   input  logic [WAYS*COST_W-1:0]   way_cost,
   input  logic [WAYS-1:0]          way_conf,
   input  logic [COST_W-1:0]        cost_thresh,
   input  logic                     miss_req,
   input  logic [$clog2(SETS)-1:0]  miss_set,
   input  logic                     hit_en,
   input  logic [$clog2(SETS)-1:0]  hit_set,
   input  logic [$clog2(WAYS)-1:0]  hit_way,
   input  logic                     fill_en,
   input  logic [$clog2(SETS)-1:0]  fill_set,
   input  logic [$clog2(WAYS)-1:0]  fill_way,
   output logic [$clog2(WAYS)-1:0]  victim_way,
   output logic                     victim_valid
);

   import cvs_pkg::*;

   localparam int WAY_W = $clog2(WAYS);

   generate
      if (!is_pow2(WAYS)) begin : g_bad_ways
         $error("cost_victim_sel: WAYS must be a power of two of at least 2");
      end
      if (!is_pow2(SETS)) begin : g_bad_sets
         $error("cost_victim_sel: SETS must be a power of two of at least 2");
      end
      if (COST_W < 1) begin : g_bad_cost
         $error("cost_victim_sel: COST_W must be at least 1");
      end
      if (LFSR_W < WAY_W + 4 || LFSR_W > 64) begin : g_bad_lfsr
         $error("cost_victim_sel: LFSR_W must be between WAY_W+4 and 64");
      end
   endgenerate

   logic [WAYS-1:0]   empty_mask;
   logic [WAYS-1:0]   cheap_mask;
   logic [LFSR_W-1:0] rnd;
   logic [WAY_W-1:0]  empty_way;
   logic [WAY_W-1:0]  cheap_way;
   logic [WAY_W-1:0]  aged_way;
   logic              empty_any;
   logic              cheap_any;
   victim_src_e       src;
   logic [WAY_W-1:0]  pick_way;

   assign empty_mask = ~way_valid;

   for (genvar w = 0; w < WAYS; w++) begin : g_cheap
      logic [COST_W-1:0] cost_w;
      assign cost_w        = way_cost[w*COST_W +: COST_W];
      assign cheap_mask[w] = way_conf[w] && (cost_w > cost_thresh);
   end

   cvs_lfsr #(
      .LFSR_W (LFSR_W),
      .POLY   (LFSR_POLY),
      .SEED   (LFSR_SEED)
   ) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .state (rnd)
   );

   // Lowest empty way: a pick with a zero random index takes the first set bit.
   cvs_pick #(
      .WAYS  (WAYS),
      .RND_W (LFSR_W)
   ) u_pick_empty (
      .mask (empty_mask),
      .rnd  ('0),
      .sel  (empty_way),
      .any  (empty_any)
   );

   cvs_pick #(
      .WAYS  (WAYS),
      .RND_W (LFSR_W)
   ) u_pick_cheap (
      .mask (cheap_mask),
      .rnd  (rnd),
      .sel  (cheap_way),
      .any  (cheap_any)
   );

   cvs_recency #(
      .WAYS (WAYS),
      .SETS (SETS)
   ) u_recency (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit_en   (hit_en),
      .hit_set  (hit_set),
      .hit_way  (hit_way),
      .fill_en  (fill_en),
      .fill_set (fill_set),
      .fill_way (fill_way),
      .rd_set   (miss_set),
      .lru_way  (aged_way)
   );

   always_comb begin
      if (empty_any) begin
         src = SRC_EMPTY;
      end else if (cheap_any) begin
         src = SRC_CHEAP;
      end else begin
         src = SRC_AGED;
      end
   end

   always_comb begin
      unique case (src)
         SRC_EMPTY: pick_way = empty_way;
         SRC_CHEAP: pick_way = cheap_way;
         default:   pick_way = aged_way;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         victim_valid <= 1'b0;
         victim_way   <= '0;
      end else begin
         victim_valid <= miss_req;
         if (miss_req) begin
            victim_way <= pick_way;
         end
      end
   end

endmodule

// File: rtl/cvs_checker.sv
module cvs_checker #(
   parameter int WAYS   = 8,
   parameter int SETS   = 16,
   parameter int COST_W = 5
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [WAYS-1:0]         way_valid,
   input logic [WAYS*COST_W-1:0]  way_cost,
   input logic [WAYS-1:0]         way_conf,
   input logic [COST_W-1:0]       cost_thresh,
   input logic                    miss_req,
   input logic [$clog2(WAYS)-1:0] victim_way,
   input logic                    victim_valid
);

   logic [WAYS-1:0] now_cheap;
   logic [WAYS-1:0] held_empty;
   logic [WAYS-1:0] held_cheap;
   logic [WAYS-1:0] below_victim;

   always_comb begin
      for (int w = 0; w < WAYS; w++) begin
         now_cheap[w] = (way_cost[w*COST_W +: COST_W] > cost_thresh) && way_conf[w];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_empty <= '0;
         held_cheap <= '0;
      end else if (miss_req) begin
         held_empty <= ~way_valid;
         held_cheap <= now_cheap;
      end
   end

   assign below_victim = (WAYS'(1) << victim_way) - WAYS'(1);

   assert_valid_after_miss_R1: assert property (@(posedge clk) disable iff (!rst_n)
      miss_req |=> victim_valid);

   assert_quiet_without_miss_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !miss_req |=> !victim_valid);

   assert_empty_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (victim_valid && (held_empty != '0)) |->
         (held_empty[victim_way] && ((held_empty & below_victim) == '0)));

   assert_cheap_member_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (victim_valid && (held_empty == '0) && (held_cheap != '0)) |->
         held_cheap[victim_way]);

   assert_single_cheap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (victim_valid && (held_empty == '0) && ($countones(held_cheap) == 1)) |->
         (held_cheap == (WAYS'(1) << victim_way)));

endmodule

bind cost_victim_sel cvs_checker #(
   .WAYS   (WAYS),
   .SETS   (SETS),
   .COST_W (COST_W)
) u_cvs_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .way_valid    (way_valid),
   .way_cost     (way_cost),
   .way_conf     (way_conf),
   .cost_thresh  (cost_thresh),
   .miss_req     (miss_req),
   .victim_way   (victim_way),
   .victim_valid (victim_valid)
);

// File: tb/cost_victim_sel_test.sv
`timescale 1ns/1ps
module cost_victim_sel_test;

   localparam int WAYS   = 8;
   localparam int SETS   = 16;
   localparam int COST_W = 5;
   localparam int WAY_W  = $clog2(WAYS);
   localparam int SET_W  = $clog2(SETS);
   localparam real HALF  = 10.0;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic [WAYS-1:0]         way_valid = '1;
   logic [WAYS*COST_W-1:0]  way_cost = '0;
   logic [WAYS-1:0]         way_conf = '0;
   logic [COST_W-1:0]       cost_thresh = '0;
   logic                    miss_req = 1'b0;
   logic [SET_W-1:0]        miss_set = '0;
   logic                    hit_en = 1'b0;
   logic [SET_W-1:0]        hit_set = '0;
   logic [WAY_W-1:0]        hit_way = '0;
   logic                    fill_en = 1'b0;
   logic [SET_W-1:0]        fill_set = '0;
   logic [WAY_W-1:0]        fill_way = '0;
   logic [WAY_W-1:0]        victim_way;
   logic                    victim_valid;

   always #(HALF) clk = ~clk;

   cost_victim_sel #(
      .WAYS   (WAYS),
      .SETS   (SETS),
      .COST_W (COST_W)
   ) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .way_valid    (way_valid),
      .way_cost     (way_cost),
      .way_conf     (way_conf),
      .cost_thresh  (cost_thresh),
      .miss_req     (miss_req),
      .miss_set     (miss_set),
      .hit_en       (hit_en),
      .hit_set      (hit_set),
      .hit_way      (hit_way),
      .fill_en      (fill_en),
      .fill_set     (fill_set),
      .fill_way     (fill_way),
      .victim_way   (victim_way),
      .victim_valid (victim_valid)
   );

   // Behavioural model: per-set list of ways, front = most recent.
   int order [SETS][$];

   int    n_checks = 0;
   int    n_fail   = 0;
   string scen     = "";

   // Stimulus for the next cycle.
   bit        s_miss, s_hit, s_fill;
   int        s_mset, s_hset, s_hway, s_fset, s_fway, s_thr;
   bit [WAYS-1:0] s_valid, s_conf;
   int        s_cost [WAYS];

   // Expectation for the output after the cycle.
   bit            e_valid;
   int            e_kind;     // 1 exact, 2 membership
   int            e_way;
   bit [WAYS-1:0] e_mask;
   string         e_tag;
   bit [WAYS-1:0] picked;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", tag, scen, act, exp, $time);
      end
   endtask

   task automatic touch(input int s, input int w);
      foreach (order[s][i]) begin
         if (order[s][i] == w) begin
            order[s].delete(i);
            break;
         end
      end
      order[s].push_front(w);
   endtask

   task automatic clear_stim();
      s_miss = 0; s_hit = 0; s_fill = 0;
      s_mset = 0; s_hset = 0; s_hway = 0; s_fset = 0; s_fway = 0;
   endtask

   task automatic cycle();
      bit [WAYS-1:0] cheap;
      // expectation from state before this cycle's updates (R9)
      e_valid = s_miss;
      cheap = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (s_conf[w] && (s_cost[w] > s_thr)) cheap[w] = 1'b1;
      end
      if (s_miss) begin
         if (s_valid != '1) begin
            e_kind = 1; e_tag = "R2";
            e_way = 0;
            for (int w = WAYS - 1; w >= 0; w--) if (!s_valid[w]) e_way = w;
         end else if (cheap != '0) begin
            e_mask = cheap;
            if ($countones(cheap) == 1) begin
               e_kind = 1; e_tag = "R3";
               for (int w = 0; w < WAYS; w++) if (cheap[w]) e_way = w;
            end else begin
               e_kind = 2; e_tag = "R4";
            end
         end else begin
            e_kind = 1; e_tag = "R6";
            e_way = order[s_mset][$];
         end
      end
      // model recency update: fill wins over a hit to the same set (R8)
      if (s_fill) touch(s_fset, s_fway);
      if (s_hit && !(s_fill && (s_fset == s_hset))) touch(s_hset, s_hway);
      // drive
      miss_req    = s_miss;
      miss_set    = SET_W'(s_mset);
      hit_en      = s_hit;
      hit_set     = SET_W'(s_hset);
      hit_way     = WAY_W'(s_hway);
      fill_en     = s_fill;
      fill_set    = SET_W'(s_fset);
      fill_way    = WAY_W'(s_fway);
      way_valid   = s_valid;
      way_conf    = s_conf;
      cost_thresh = COST_W'(s_thr);
      for (int w = 0; w < WAYS; w++) way_cost[w*COST_W +: COST_W] = COST_W'(s_cost[w]);
      @(posedge clk);
      @(negedge clk);
      check(victim_valid == e_valid, "R1", int'(victim_valid), int'(e_valid));
      if (e_valid) begin
         if (e_kind == 1) begin
            check(int'(victim_way) == e_way, e_tag, int'(victim_way), e_way);
         end else begin
            check(e_mask[victim_way], e_tag, int'(victim_way), int'(e_mask));
            picked[victim_way] = 1'b1;
         end
      end
      clear_stim();
   endtask

   task automatic plain_set();
      s_valid = '1; s_conf = '0; s_thr = 0;
      for (int w = 0; w < WAYS; w++) s_cost[w] = 0;
   endtask

   task automatic miss_on(input int s);
      s_miss = 1; s_mset = s;
      cycle();
   endtask

   initial begin
      #(HALF * 2.0 * 200000.0);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      for (int s = 0; s < SETS; s++) begin
         for (int w = 0; w < WAYS; w++) order[s].push_back(w);
      end
      clear_stim();
      plain_set();
      picked = '0;
      repeat (3) @(negedge clk);
      scen = "reset";
      check(victim_valid == 1'b0, "R1", int'(victim_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(victim_valid == 1'b0, "R1", int'(victim_valid), 0);

      // R7: reset order makes the highest way least recent; R6 fallback
      scen = "reset order";
      miss_on(0);
      check(victim_way == WAY_W'(WAYS - 1), "R7", int'(victim_way), WAYS - 1);
      cycle();

      // R7: hits reorder set 2
      scen = "hit reorder";
      s_hit = 1; s_hset = 2; s_hway = 7; cycle();
      s_hit = 1; s_hset = 2; s_hway = 3; cycle();
      miss_on(2);                       // expect 6
      s_fill = 1; s_fset = 2; s_fway = 6; cycle();
      miss_on(2);                       // expect 5

      // R10: other sets untouched
      scen = "set isolation R10";
      miss_on(5);
      miss_on(9);

      // R8: fill and hit to same set in one cycle, fill only applies
      scen = "fill beats hit R8";
      s_fill = 1; s_fset = 3; s_fway = 7;
      s_hit = 1; s_hset = 3; s_hway = 6; cycle();
      miss_on(3);                       // expect 6
      // different sets in one cycle: both apply
      s_fill = 1; s_fset = 10; s_fway = 7;
      s_hit = 1; s_hset = 11; s_hway = 7; cycle();
      miss_on(10);
      miss_on(11);

      // R9: miss sees order before a same-cycle hit
      scen = "pre-update read R9";
      s_miss = 1; s_mset = 4; s_hit = 1; s_hset = 4; s_hway = 7; cycle();
      miss_on(4);                       // expect 6

      // R2: empty ways first, lowest index, even with cheap ways present
      scen = "empty priority R2";
      s_valid = 8'b1101_0111; s_conf = '1; s_thr = 0;
      for (int w = 0; w < WAYS; w++) s_cost[w] = 20;
      miss_on(1);
      s_valid = 8'b0111_1111;
      miss_on(1);
      plain_set();

      // R3: threshold boundary and confidence
      scen = "threshold R3";
      s_thr = 10;
      s_cost[2] = 10; s_conf[2] = 1;
      s_cost[4] = 11; s_conf[4] = 0;
      s_cost[6] = 11; s_conf[6] = 1;
      miss_on(7);                       // exact 6
      s_conf[6] = 0;
      miss_on(7);                       // none cheap -> LRU
      for (int w = 0; w < WAYS; w++) begin s_cost[w] = 31; s_conf[w] = 1; end
      s_thr = 31;
      miss_on(7);                       // nothing exceeds 31 -> LRU
      plain_set();

      // R4 and R5: several cheap candidates over back-to-back misses
      scen = "random spread R5";
      picked = '0;
      s_thr = 5;
      s_cost[1] = 9; s_conf[1] = 1;
      s_cost[4] = 30; s_conf[4] = 1;
      s_cost[6] = 6; s_conf[6] = 1;
      for (int i = 0; i < 40; i++) begin
         s_valid = '1; s_conf = 8'b0101_0010; s_thr = 5;
         s_cost[1] = 9; s_cost[4] = 30; s_cost[6] = 6;
         miss_on(i % SETS);
      end
      check($countones(picked) >= 2, "R5", $countones(picked), 2);
      plain_set();

      // mixed random traffic against the model
      scen = "random mix";
      for (int i = 0; i < 600; i++) begin
         s_miss = ($urandom_range(0, 3) != 0);
         s_mset = $urandom_range(0, SETS - 1);
         s_hit  = $urandom_range(0, 1);
         s_hset = $urandom_range(0, SETS - 1);
         s_hway = $urandom_range(0, WAYS - 1);
         s_fill = ($urandom_range(0, 2) == 0);
         s_fset = ($urandom_range(0, 3) == 0) ? s_hset : $urandom_range(0, SETS - 1);
         s_fway = $urandom_range(0, WAYS - 1);
         s_valid = ($urandom_range(0, 4) == 0) ? WAYS'($urandom) : '1;
         s_conf  = WAYS'($urandom);
         s_thr   = $urandom_range(0, 31);
         for (int w = 0; w < WAYS; w++) s_cost[w] = $urandom_range(0, 31);
         cycle();
      end

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule